// File: doc/BRIEF.md
# DMA Packet Splitter with Outstanding-Packet Limit

This block sits between a DMA port and a line-granular memory path. It takes byte-granular packets (start address, byte length, direction) and breaks each one into line-sized chunks. The first chunk starts at the packet's offset within its line and runs no further than the end of that line. Every later chunk starts on a line boundary and is at most one line long. Many packets can be in flight together. Each one occupies a slot in a table whose key is the line address of the packet's start. The slot records the start address, the total length, the direction, the bytes issued so far and the bytes completed so far.

Only one chunk per packet is outstanding at a time. When the memory side reports a chunk complete, the block sets the completed count to the issued count. It then either issues the next chunk or, if the whole length is done, frees the slot and signals packet completion. For read packets, each completion's line data is shifted so that the packet's bytes start at byte 0. The data is handed out together with the position in the packet buffer where it belongs. Every chunk carries the slot index, so completions find their packet even when the chunk's line differs from the table key.

A packet is refused when the table already holds the configured maximum number of packets, or when its start line is already tracked. The status is returned combinationally in the same cycle as the handshake.

Top module: `dma_pkt_splitter`

## Requirements
- R1: A packet presented with pkt_valid_i while pkt_ready_o is high, with fewer than MAX_OUT packets tracked and its start line not tracked, gets pkt_status_o = 0 (accepted) in that cycle, and pkt_tag_o gives the slot index it is recorded in. One cycle later its first chunk appears on chk_valid_o with chk_addr_o equal to the packet start address, chk_write_o equal to the direction, and chk_tag_o equal to that slot.
- R2: When MAX_OUT packets are tracked, a presented packet gets pkt_status_o = 1 (buffer full). It is not recorded, and no chunk is issued for it.
- R3: When the line address (address bits above the line offset) of a presented packet equals that of a tracked packet's start address, the packet gets pkt_status_o = 2 (aliased). It is not recorded, and no chunk is issued for it.
- R4: The first chunk length is the smaller of the packet length and the bytes from the start offset to the end of the line.
- R5: One cycle after a completion (cmp_valid_i with cmp_tag_i naming a tracked slot) that does not finish its packet, the next chunk is issued. Its address is start plus bytes issued, which is line aligned, and its length is the smaller of the bytes remaining and LINE_BYTES.
- R6: One cycle after the completion that finishes a packet, done_valid_o pulses with done_tag_o naming the slot. The slot is freed, so its line can be accepted again and the outstanding count falls by one.
- R7: One cycle after each read completion, rd_valid_o pulses. rd_pos_o holds the bytes completed before that chunk and rd_cnt_o holds the chunk length. rd_data_o byte 0 holds the returned line's byte at the start offset for the first chunk, or at offset 0 for later chunks. Write completions never raise rd_valid_o.
- R8: busy_o is high exactly when at least one packet is tracked.
- R9: pkt_ready_o is low in any cycle where cmp_valid_i is high, so that completions take priority over new packets. Packet lengths are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pkt_valid_i | input | 1 | Packet presented |
| pkt_ready_o | output | 1 | Packet handshake ready |
| pkt_addr_i | input | ADDR_W | Packet start byte address |
| pkt_len_i | input | LEN_W | Packet byte length (nonzero) |
| pkt_write_i | input | 1 | 1 = write, 0 = read |
| pkt_status_o | output | 2 | 0 accepted, 1 buffer full, 2 aliased |
| pkt_tag_o | output | IDX_W | Slot given to an accepted packet |
| chk_valid_o | output | 1 | Chunk issued |
| chk_addr_o | output | ADDR_W | Chunk start byte address |
| chk_len_o | output | CLEN_W | Chunk byte count |
| chk_write_o | output | 1 | Chunk direction |
| chk_tag_o | output | IDX_W | Slot of the chunk's packet |
| cmp_valid_i | input | 1 | Chunk completion |
| cmp_tag_i | input | IDX_W | Slot of completed chunk |
| cmp_data_i | input | 8*LINE_BYTES | Returned line data (reads) |
| rd_valid_o | output | 1 | Read data ready to place |
| rd_tag_o | output | IDX_W | Slot of the read data |
| rd_pos_o | output | LEN_W | Byte position in packet buffer |
| rd_cnt_o | output | CLEN_W | Number of valid bytes |
| rd_data_o | output | 8*LINE_BYTES | Aligned read bytes |
| done_valid_o | output | 1 | Packet finished |
| done_tag_o | output | IDX_W | Slot of finished packet |
| busy_o | output | 1 | At least one packet tracked |

## Verification
The bench goes after packets that start mid-line, packets that end exactly on a line boundary, single-byte packets at the last byte of a line, and packets that cross several lines. A wrong first-chunk clamp would show up there as overlong or misaligned chunks, and a wrong offset choice would put the wrong bytes at rd_data_o byte 0. It fills the table to the limit and then checks the refusal. A counter that is off by one would either accept a 65th packet or refuse the 64th. It also presents a packet whose line is already tracked, then presents the same line again after the first packet finishes. A design that never freed slots, or that compared full addresses instead of lines, would fail these checks.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;
  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_FULL  = 2'd1,
    ST_ALIAS = 2'd2
  } pkt_status_e;
endpackage

// File: rtl/dma_split_chunk.sv
// Chunk length: min(remaining, bytes left in the line from addr).
module dma_split_chunk #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CLEN_W    = $clog2(LINE_BYTES + 1)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  rem_i,
  output logic [CLEN_W-1:0] len_o
);
  logic [LEN_W-1:0] room;
  assign room  = LEN_W'(LINE_BYTES) - LEN_W'(addr_i[OFF_W-1:0]);
  assign len_o = (rem_i < room) ? CLEN_W'(rem_i) : CLEN_W'(room);
endmodule

// File: rtl/dma_split_lookup.sv
// Line-key match across tracked slots plus first-free slot select.
module dma_split_lookup #(
  parameter int N     = 64,
  parameter int KEY_W = 26,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            vld_i,
  input  logic [N-1:0][KEY_W-1:0] key_i,
  input  logic [KEY_W-1:0]        probe_i,
  output logic                    hit_o,
  output logic                    free_o,
  output logic [IDX_W-1:0]        free_idx_o
);
  logic [N-1:0] hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = vld_i[g] && (key_i[g] == probe_i);
  end

  assign hit_o  = |hit_vec;
  assign free_o = ~&vld_i;

  always_comb begin
    free_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_i[i]) free_idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dma_split_align.sv
// Shift returned line right by a byte offset.
module dma_split_align #(
  parameter int LINE_BYTES = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = 8 * LINE_BYTES
) (
  input  logic [LINE_W-1:0] data_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [LINE_W-1:0] data_o
);
  assign data_o = data_i >> {off_i, 3'b000};
endmodule

// File: rtl/dma_pkt_splitter.sv
module dma_pkt_splitter
  import dma_split_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64,
  parameter int MAX_OUT    = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int KEY_W     = ADDR_W - OFF_W,
  localparam int LINE_W    = 8 * LINE_BYTES,
  localparam int IDX_W     = $clog2(MAX_OUT),
  localparam int CNT_W     = $clog2(MAX_OUT + 1),
  localparam int CLEN_W    = $clog2(LINE_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pkt_valid_i,
  output logic              pkt_ready_o,
  input  logic [ADDR_W-1:0] pkt_addr_i,
  input  logic [LEN_W-1:0]  pkt_len_i,
  input  logic              pkt_write_i,
  output logic [1:0]        pkt_status_o,
  output logic [IDX_W-1:0]  pkt_tag_o,
  output logic              chk_valid_o,
  output logic [ADDR_W-1:0] chk_addr_o,
  output logic [CLEN_W-1:0] chk_len_o,
  output logic              chk_write_o,
  output logic [IDX_W-1:0]  chk_tag_o,
  input  logic              cmp_valid_i,
  input  logic [IDX_W-1:0]  cmp_tag_i,
  input  logic [LINE_W-1:0] cmp_data_i,
  output logic              rd_valid_o,
  output logic [IDX_W-1:0]  rd_tag_o,
  output logic [LEN_W-1:0]  rd_pos_o,
  output logic [CLEN_W-1:0] rd_cnt_o,
  output logic [LINE_W-1:0] rd_data_o,
  output logic              done_valid_o,
  output logic [IDX_W-1:0]  done_tag_o,
  output logic              busy_o
);

  // request table
  logic [MAX_OUT-1:0]              tbl_vld;
  logic [MAX_OUT-1:0][ADDR_W-1:0]  tbl_start;
  logic [MAX_OUT-1:0][LEN_W-1:0]   tbl_len;
  logic [MAX_OUT-1:0][LEN_W-1:0]   tbl_iss;
  logic [MAX_OUT-1:0][LEN_W-1:0]   tbl_cmp;
  logic [MAX_OUT-1:0]              tbl_wr;
  logic [MAX_OUT-1:0][KEY_W-1:0]   tbl_key;
  logic [CNT_W-1:0]                out_cnt;

  for (genvar g = 0; g < MAX_OUT; g++) begin : g_key
    assign tbl_key[g] = tbl_start[g][ADDR_W-1:OFF_W];
  end

  // accept path
  logic             hit, free_any;
  logic [IDX_W-1:0] free_idx;
  logic [CLEN_W-1:0] acc_clen;
  pkt_status_e      st;
  logic             acc_fire;

  dma_split_lookup #(.N(MAX_OUT), .KEY_W(KEY_W)) u_lookup (
    .vld_i      (tbl_vld),
    .key_i      (tbl_key),
    .probe_i    (pkt_addr_i[ADDR_W-1:OFF_W]),
    .hit_o      (hit),
    .free_o     (free_any),
    .free_idx_o (free_idx)
  );

  dma_split_chunk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)) u_first (
    .addr_i (pkt_addr_i),
    .rem_i  (pkt_len_i),
    .len_o  (acc_clen)
  );

  always_comb begin
    if (out_cnt == CNT_W'(MAX_OUT) || !free_any) st = ST_FULL;
    else if (hit)                                st = ST_ALIAS;
    else                                         st = ST_OK;
  end

  assign pkt_ready_o  = !cmp_valid_i;
  assign pkt_status_o = st;
  assign pkt_tag_o    = free_idx;
  assign acc_fire     = pkt_valid_i && pkt_ready_o && (st == ST_OK);

  // completion path
  logic [ADDR_W-1:0] c_start, c_next;
  logic [LEN_W-1:0]  c_len, c_iss, c_cmp, c_rem;
  logic              c_wr, c_last, cmp_fire;
  logic [CLEN_W-1:0] nxt_clen;
  logic [OFF_W-1:0]  rd_off;
  logic [LINE_W-1:0] aligned;

  assign c_start  = tbl_start[cmp_tag_i];
  assign c_len    = tbl_len[cmp_tag_i];
  assign c_iss    = tbl_iss[cmp_tag_i];
  assign c_cmp    = tbl_cmp[cmp_tag_i];
  assign c_wr     = tbl_wr[cmp_tag_i];
  assign c_last   = (c_iss == c_len);
  assign cmp_fire = cmp_valid_i && tbl_vld[cmp_tag_i];
  assign c_next   = c_start + ADDR_W'(c_iss);
  assign c_rem    = c_len - c_iss;
  // first chunk's data sits at the start offset; later chunks at byte 0
  assign rd_off   = (c_cmp == '0) ? c_start[OFF_W-1:0] : '0;

  dma_split_chunk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)) u_next (
    .addr_i (c_next),
    .rem_i  (c_rem),
    .len_o  (nxt_clen)
  );

  dma_split_align #(.LINE_BYTES(LINE_BYTES)) u_align (
    .data_i (cmp_data_i),
    .off_i  (rd_off),
    .data_o (aligned)
  );

  // table state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_vld <= '0;
      out_cnt <= '0;
    end else begin
      if (acc_fire) tbl_vld[free_idx] <= 1'b1;
      if (cmp_fire && c_last) tbl_vld[cmp_tag_i] <= 1'b0;
      out_cnt <= out_cnt + CNT_W'(acc_fire) - CNT_W'(cmp_fire && c_last);
    end
  end

  always_ff @(posedge clk_i) begin
    if (acc_fire) begin
      tbl_start[free_idx] <= pkt_addr_i;
      tbl_len[free_idx]   <= pkt_len_i;
      tbl_wr[free_idx]    <= pkt_write_i;
      tbl_iss[free_idx]   <= LEN_W'(acc_clen);
      tbl_cmp[free_idx]   <= '0;
    end
    if (cmp_fire) begin
      tbl_cmp[cmp_tag_i] <= c_iss;
      if (!c_last) tbl_iss[cmp_tag_i] <= c_iss + LEN_W'(nxt_clen);
    end
  end

  // registered outputs: one cycle issue latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_valid_o  <= 1'b0;
      chk_addr_o   <= '0;
      chk_len_o    <= '0;
      chk_write_o  <= 1'b0;
      chk_tag_o    <= '0;
      rd_valid_o   <= 1'b0;
      rd_tag_o     <= '0;
      rd_pos_o     <= '0;
      rd_cnt_o     <= '0;
      rd_data_o    <= '0;
      done_valid_o <= 1'b0;
      done_tag_o   <= '0;
    end else begin
      chk_valid_o  <= acc_fire || (cmp_fire && !c_last);
      rd_valid_o   <= cmp_fire && !c_wr;
      done_valid_o <= cmp_fire && c_last;
      if (acc_fire) begin
        chk_addr_o  <= pkt_addr_i;
        chk_len_o   <= acc_clen;
        chk_write_o <= pkt_write_i;
        chk_tag_o   <= free_idx;
      end else if (cmp_fire && !c_last) begin
        chk_addr_o  <= c_next;
        chk_len_o   <= nxt_clen;
        chk_write_o <= c_wr;
        chk_tag_o   <= cmp_tag_i;
      end
      if (cmp_fire) begin
        rd_tag_o   <= cmp_tag_i;
        rd_pos_o   <= c_cmp;
        rd_cnt_o   <= CLEN_W'(c_iss - c_cmp);
        rd_data_o  <= aligned;
        done_tag_o <= cmp_tag_i;
      end
    end
  end

  assign busy_o = (out_cnt != '0);

endmodule

// File: rtl/dma_pkt_splitter_chk.sv
module dma_pkt_splitter_chk #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64,
  parameter int MAX_OUT    = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(MAX_OUT),
  localparam int CLEN_W    = $clog2(LINE_BYTES + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pkt_valid_i,
  input logic              pkt_ready_o,
  input logic [1:0]        pkt_status_o,
  input logic              chk_valid_o,
  input logic [ADDR_W-1:0] chk_addr_o,
  input logic [CLEN_W-1:0] chk_len_o,
  input logic              cmp_valid_i,
  input logic              rd_valid_o,
  input logic [CLEN_W-1:0] rd_cnt_o,
  input logic              done_valid_o,
  input logic              busy_o
);
  // R4, R5: chunk never empty and never crosses a line
  assert_chunk_in_line_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_o |-> (chk_len_o != '0) &&
      (32'(chk_addr_o[OFF_W-1:0]) + 32'(chk_len_o) <= LINE_BYTES));

  assert_chunk_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_o |-> $past(cmp_valid_i || (pkt_valid_i && pkt_ready_o)));

  assert_reject_no_chunk_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && pkt_ready_o && pkt_status_o != 2'd0) |=> !chk_valid_o);

  assert_full_only_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_status_o == 2'd1) |-> busy_o);

  assert_done_after_cmp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |-> $past(cmp_valid_i) && $past(busy_o));

  assert_rd_cnt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_cnt_o != '0) && (32'(rd_cnt_o) <= LINE_BYTES));

  assert_accept_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && pkt_ready_o && pkt_status_o == 2'd0) |=> busy_o);

  assert_cmp_priority_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && pkt_valid_i) |=> !chk_valid_o || $past(busy_o));
endmodule

bind dma_pkt_splitter dma_pkt_splitter_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES), .MAX_OUT(MAX_OUT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pkt_valid_i  (pkt_valid_i),
  .pkt_ready_o  (pkt_ready_o),
  .pkt_status_o (pkt_status_o),
  .chk_valid_o  (chk_valid_o),
  .chk_addr_o   (chk_addr_o),
  .chk_len_o    (chk_len_o),
  .cmp_valid_i  (cmp_valid_i),
  .rd_valid_o   (rd_valid_o),
  .rd_cnt_o     (rd_cnt_o),
  .done_valid_o (done_valid_o),
  .busy_o       (busy_o)
);

// File: tb/dma_pkt_splitter_tb.sv
module dma_pkt_splitter_tb;
  localparam int ADDR_W = 32, LEN_W = 16, LINE_BYTES = 64, MAX_OUT = 64;
  localparam int LINE_W = 8 * LINE_BYTES, IDX_W = 6, CLEN_W = 7;

  logic clk = 0, rst_ni = 0;
  always #2 clk = ~clk;  // 250 MHz

  logic              pkt_valid = 0, pkt_write = 0;
  logic [ADDR_W-1:0] pkt_addr = '0;
  logic [LEN_W-1:0]  pkt_len = '0;
  logic              pkt_ready;
  logic [1:0]        pkt_status;
  logic [IDX_W-1:0]  pkt_tag;
  logic              chk_valid, chk_write;
  logic [ADDR_W-1:0] chk_addr;
  logic [CLEN_W-1:0] chk_len;
  logic [IDX_W-1:0]  chk_tag;
  logic              cmp_valid = 0;
  logic [IDX_W-1:0]  cmp_tag = '0;
  logic [LINE_W-1:0] cmp_data = '0;
  logic              rd_valid, done_valid, busy;
  logic [IDX_W-1:0]  rd_tag, done_tag;
  logic [LEN_W-1:0]  rd_pos;
  logic [CLEN_W-1:0] rd_cnt;
  logic [LINE_W-1:0] rd_data;

  dma_pkt_splitter u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .pkt_valid_i(pkt_valid), .pkt_ready_o(pkt_ready), .pkt_addr_i(pkt_addr),
    .pkt_len_i(pkt_len), .pkt_write_i(pkt_write), .pkt_status_o(pkt_status),
    .pkt_tag_o(pkt_tag), .chk_valid_o(chk_valid), .chk_addr_o(chk_addr),
    .chk_len_o(chk_len), .chk_write_o(chk_write), .chk_tag_o(chk_tag),
    .cmp_valid_i(cmp_valid), .cmp_tag_i(cmp_tag), .cmp_data_i(cmp_data),
    .rd_valid_o(rd_valid), .rd_tag_o(rd_tag), .rd_pos_o(rd_pos),
    .rd_cnt_o(rd_cnt), .rd_data_o(rd_data), .done_valid_o(done_valid),
    .done_tag_o(done_tag), .busy_o(busy)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] mk_line(input int seed);
    logic [LINE_W-1:0] l;
    for (int k = 0; k < LINE_BYTES; k++) l[8*k +: 8] = 8'(k * 3 + seed);
    return l;
  endfunction

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic send(input int addr, input int len, input bit wr,
                      output int st, output int tag);
    @(negedge clk);
    pkt_valid = 1; pkt_addr = ADDR_W'(addr); pkt_len = LEN_W'(len); pkt_write = wr;
    #1;
    st = int'(pkt_status); tag = int'(pkt_tag);
    @(negedge clk);
    pkt_valid = 0;
  endtask

  task automatic complete(input int tag, input int seed);
    @(negedge clk);
    cmp_valid = 1; cmp_tag = IDX_W'(tag); cmp_data = mk_line(seed);
    pkt_valid = 1;  // offered alongside: must not be taken
    pkt_addr = 32'h00F0_0000; pkt_len = 16'd4; pkt_write = 0;
    #1;
    check(pkt_ready == 1'b0, "R9 ready low during completion", pkt_ready, 0);
    @(negedge clk);
    cmp_valid = 0; pkt_valid = 0;
  endtask

  // addr, len, write
  typedef struct packed { logic [31:0] addr; logic [15:0] len; logic wr; } vec_t;
  localparam vec_t VECS [6] = '{
    '{32'h0000_1000, 16'd64,  1'b0},
    '{32'h0000_2010, 16'd16,  1'b0},
    '{32'h0000_3030, 16'd100, 1'b1},
    '{32'h0000_403F, 16'd1,   1'b0},
    '{32'h0000_5005, 16'd200, 1'b0},
    '{32'h0000_6000, 16'd128, 1'b1}
  };

  int tags[MAX_OUT];

  initial begin
    int st, tag;
    repeat (3) @(negedge clk);
    check(busy == 0, "R8 reset busy", busy, 0);
    check(chk_valid == 0, "R1 reset chunk idle", chk_valid, 0);
    check(pkt_ready == 1, "R9 reset ready", pkt_ready, 1);
    rst_ni = 1;
    @(negedge clk);

    // table walk
    for (int v = 0; v < 6; v++) begin
      int addr, len, off, iss, cmp, clen, seed;
      bit wr;
      addr = int'(VECS[v].addr); len = int'(VECS[v].len); wr = VECS[v].wr;
      off = addr % LINE_BYTES;
      send(addr, len, wr, st, tag);
      check(st == 0, "R1 accept status", st, 0);
      check(chk_valid && chk_tag == IDX_W'(tag) && chk_write == wr,
            "R1 first chunk issued", chk_tag, tag);
      check(chk_addr == ADDR_W'(addr), "R1 first chunk addr", chk_addr, addr);
      clen = min2(len, LINE_BYTES - off);
      check(int'(chk_len) == clen, "R4 first chunk len", chk_len, clen);
      check(busy == 1, "R8 busy with packet", busy, 1);
      iss = clen; cmp = 0;
      while (1) begin
        int eoff;
        seed = v * 17 + cmp;
        complete(tag, seed);
        eoff = (cmp == 0) ? off : 0;
        if (!wr) begin
          check(rd_valid && int'(rd_pos) == cmp, "R7 read pos", rd_pos, cmp);
          check(int'(rd_cnt) == iss - cmp, "R7 read count", rd_cnt, iss - cmp);
          check(rd_data[7:0] == 8'(eoff * 3 + seed), "R7 aligned byte0",
                rd_data[7:0], 8'(eoff * 3 + seed));
          check(rd_data[8*(iss-cmp-1) +: 8] == 8'((eoff + iss - cmp - 1) * 3 + seed),
                "R7 aligned last byte", rd_data[8*(iss-cmp-1) +: 8],
                8'((eoff + iss - cmp - 1) * 3 + seed));
        end else begin
          check(rd_valid == 0, "R7 no read data on write", rd_valid, 0);
        end
        cmp = iss;
        if (iss == len) begin
          check(done_valid && int'(done_tag) == tag, "R6 done pulse", done_tag, tag);
          check(chk_valid == 0, "R6 no chunk after last", chk_valid, 0);
          break;
        end
        clen = min2(len - iss, LINE_BYTES);
        check(chk_valid && chk_addr == ADDR_W'(addr + iss), "R5 next chunk addr",
              chk_addr, addr + iss);
        check(int'(chk_len) == clen, "R5 next chunk len", chk_len, clen);
        check(done_valid == 0, "R6 no early done", done_valid, 1);
        iss += clen;
      end
      check(busy == 0, "R8 idle after packet", busy, 0);
    end

    // aliasing
    send(32'h7000, 10, 0, st, tag);
    check(st == 0, "R1 accept before alias", st, 0);
    tags[0] = tag;
    send(32'h7020, 4, 1, st, tag);
    check(st == 2, "R3 aliased status", st, 2);
    check(chk_valid == 0, "R3 no chunk on alias", chk_valid, 0);
    send(32'h7040, 4, 0, st, tag);
    check(st == 0, "R3 next line not aliased", st, 0);
    tags[1] = tag;
    complete(tags[0], 1);
    check(done_valid == 1, "R6 alias holder done", done_valid, 1);
    send(32'h7020, 4, 1, st, tag);
    check(st == 0, "R6 line free after done", st, 0);
    complete(tag, 2);
    complete(tags[1], 3);
    check(busy == 0, "R8 idle after alias test", busy, 0);

    // buffer full
    for (int i = 0; i < MAX_OUT; i++) begin
      send(32'h10_0000 + i * LINE_BYTES, 1, 0, st, tag);
      check(st == 0, "R1 fill accept", st, 0);
      tags[i] = tag;
    end
    send(32'h20_0000, 1, 0, st, tag);
    check(st == 1, "R2 buffer full status", st, 1);
    check(chk_valid == 0, "R2 no chunk when full", chk_valid, 0);
    check(busy == 1, "R8 busy when full", busy, 1);
    complete(tags[5], 4);
    check(done_valid && int'(done_tag) == tags[5], "R6 done frees slot", done_tag, tags[5]);
    send(32'h20_0000, 1, 0, st, tag);
    check(st == 0, "R6 accept after count drop", st, 0);
    tags[5] = tag;
    for (int i = 0; i < MAX_OUT; i++) complete(tags[i], i);
    check(busy == 0, "R8 idle after drain", busy, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule